// File: doc/BRIEF.md
# Parallel Self-Synchronizing Video Descrambler

This block sits behind a serial receiver that has already cut a serial digital video stream into 10-bit parallel characters. It takes one character per clock, at a 27 MHz character rate or 270 Mbit/s of serial bits. It undoes the transmitter's line coding in two stages, all ten bits in a single clock. The first stage removes the self-synchronizing scrambling defined by the polynomial x^9 + x^4 + 1. The second stage turns the NRZI-coded result back into plain NRZ bits.

Both stages keep a bit history that runs from one character into the next, so the ten bits of a character are handled exactly as a bit-serial decoder would handle them. Because the descrambler works only on received bits, no start-up alignment is needed: any stream becomes correct after the first character. A bypass control sends the raw characters to the output. This suits streams that are not coded this way, and diagnostics. Framing on sync words and 8B/10B decoding happen elsewhere.

Top module: `sdv_descrambler_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, out_valid is 0 and out_data is 0. Reset clears both bit histories to zero.
- R2: Bit 0 of a character is the earliest bit in serial time. The descrambled bit for each received bit r is r XOR (the received bit 4 positions earlier) XOR (the received bit 9 positions earlier). Positions count across character boundaries, and bits received before reset count as 0.
- R3: When bypass is 0, each output bit equals its descrambled bit XOR the descrambled bit just before it in serial order. That earlier bit is 0 for the first bit after reset.
- R4: Only cycles with in_valid=1 move the bit histories forward. Idle cycles between characters do not change the result for the characters that follow.
- R5: When bypass is 1, out_data equals the in_data of the previous cycle, with the same one-cycle latency as the decoded path.
- R6: out_valid equals the in_valid of the previous cycle.
- R7: The bit histories keep advancing while bypass is 1. The first decoded character after bypass is released is therefore the same as if bypass had never been set.
- R8: A stream that was NRZI-coded and then scrambled from any unknown scrambler state is recovered exactly from the second valid character after reset onward.
- R9: A cycle with in_valid=0 leaves out_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 10 | Received character, bit 0 earliest |
| in_valid | input | 1 | in_data holds a character this cycle |
| bypass | input | 1 | 1 selects raw characters at the output |
| out_data | output | 10 | Decoded (or raw) character, registered |
| out_valid | output | 1 | out_data was updated this cycle |

## Verification
The bench goes after the bits that reach back across a character boundary. Bits 0 to 8 of each character need history from the previous character. A design that reset or dropped its history per character would corrupt the first nine bits of every character after the first and fail the long recovered-stream test. Idle gaps and bypass stretches test the rule that only valid characters advance the history: a design that shifted on every clock would go wrong right after a gap, and one that froze during bypass would go wrong on the first character after it. The single-one character right after reset has a hand-worked result, which catches reversed bit order or swapped tap distances.

// File: rtl/sdv_desc_pkg.sv
package sdv_desc_pkg;
  // Character width and scrambler tap distances (x^9 + x^4 + 1)
  localparam int unsigned CHAR_W   = 10;
  localparam int unsigned TAP_NEAR = 4;
  localparam int unsigned TAP_FAR  = 9;

  typedef logic [CHAR_W-1:0] char_t;
endpackage

// File: rtl/sdv_scr_core.sv
// Unrolled self-synchronizing descrambler: one character per clock.
module sdv_scr_core #(
  parameter int unsigned W    = sdv_desc_pkg::CHAR_W,
  parameter int unsigned NEAR = sdv_desc_pkg::TAP_NEAR,
  parameter int unsigned FAR  = sdv_desc_pkg::TAP_FAR
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] char_i,
  output logic [W-1:0] desc_o
);
  localparam int unsigned EXT_W = W + FAR;

  logic [FAR-1:0]   hist_q;   // last FAR received bits, MSB most recent
  logic [EXT_W-1:0] ext;      // received bits in serial order

  assign ext = {char_i, hist_q};

  for (genvar i = 0; i < W; i++) begin : g_tap
    assign desc_o[i] = ext[FAR+i] ^ ext[FAR+i-NEAR] ^ ext[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  hist_q <= '0;
    else if (en) hist_q <= ext[EXT_W-1 -: FAR];
  end

  // R4: history frozen on idle cycles
  assert_hist_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(hist_q));
endmodule

// File: rtl/sdv_nrzi_dec.sv
// NRZI to NRZ conversion across a whole character per clock.
module sdv_nrzi_dec #(
  parameter int unsigned W = sdv_desc_pkg::CHAR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] desc_i,
  output logic [W-1:0] nrz_o,
  output logic         prev_o
);
  logic prev_q;  // last descrambled bit of previous valid character

  assign nrz_o[0] = desc_i[0] ^ prev_q;
  for (genvar i = 1; i < W; i++) begin : g_edge
    assign nrz_o[i] = desc_i[i] ^ desc_i[i-1];
  end
  assign prev_o = prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  prev_q <= 1'b0;
    else if (en) prev_q <= desc_i[W-1];
  end

  // R4: carry bit frozen on idle cycles
  assert_prev_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(prev_q));
endmodule

// File: rtl/sdv_out_stage.sv
// Output register with bypass selection.
module sdv_out_stage #(
  parameter int unsigned W = sdv_desc_pkg::CHAR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic         bypass_i,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] dec_i,
  output logic [W-1:0] data_o,
  output logic         valid_o
);
  logic [W-1:0] sel;
  assign sel = bypass_i ? raw_i : dec_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= sel;
    end
  end

  assert_valid_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o);
  assert_valid_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !valid_o);
  assert_bypass_raw_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && bypass_i) |=> data_o == $past(raw_i));
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(data_o));
endmodule

// File: rtl/sdv_descrambler_top.sv
module sdv_descrambler_top #(
  parameter int unsigned W    = sdv_desc_pkg::CHAR_W,
  parameter int unsigned NEAR = sdv_desc_pkg::TAP_NEAR,
  parameter int unsigned FAR  = sdv_desc_pkg::TAP_FAR
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  input  logic         bypass,
  output logic [W-1:0] out_data,
  output logic         out_valid
);
  logic [W-1:0] desc_w;
  logic [W-1:0] nrz_w;
  logic         prev_w;

  sdv_scr_core #(.W(W), .NEAR(NEAR), .FAR(FAR)) u_core (
    .clk(clk), .rst_n(rst_n), .en(in_valid),
    .char_i(in_data), .desc_o(desc_w)
  );

  sdv_nrzi_dec #(.W(W)) u_nrzi (
    .clk(clk), .rst_n(rst_n), .en(in_valid),
    .desc_i(desc_w), .nrz_o(nrz_w), .prev_o(prev_w)
  );

  sdv_out_stage #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .valid_i(in_valid), .bypass_i(bypass),
    .raw_i(in_data), .dec_i(nrz_w), .data_o(out_data), .valid_o(out_valid)
  );

  // R3: first output bit joins across the character boundary
  assert_first_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !bypass) |=> out_data[0] == $past(desc_w[0] ^ prev_w));
endmodule

// File: tb/sdv_descrambler_top_bench.sv
module sdv_descrambler_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       bypass = 1'b0;
  logic [9:0] out_data;
  logic       out_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bit-serial reference state
  logic [8:0] m_sr;
  logic       m_pd;
  logic [9:0] m_last;
  // source-side coder state (NRZI then scramble)
  logic [8:0] s_sr;
  logic       s_tp;

  always #4 clk = ~clk;

  sdv_descrambler_top u_sdv_descrambler_top (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .bypass(bypass), .out_data(out_data), .out_valid(out_valid)
  );

  task automatic check(input string req, input logic [10:0] got, input logic [10:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic model_reset();
    m_sr = '0; m_pd = 1'b0; m_last = '0;
  endtask

  task automatic model_step(input logic [9:0] ch, input logic v, input logic byp);
    logic [9:0] n;
    logic d;
    n = '0;
    if (v) begin
      for (int i = 0; i < 10; i++) begin
        d = ch[i] ^ m_sr[3] ^ m_sr[8];
        n[i] = d ^ m_pd;
        m_pd = d;
        m_sr = {m_sr[7:0], ch[i]};
      end
      m_last = byp ? ch : n;
    end
  endtask

  function automatic logic [9:0] encode(input logic [9:0] src);
    logic [9:0] r;
    logic t;
    for (int i = 0; i < 10; i++) begin
      t = src[i] ^ s_tp;
      s_tp = t;
      r[i] = t ^ s_sr[3] ^ s_sr[8];
      s_sr = {s_sr[7:0], r[i]};
    end
    return r;
  endfunction

  // drive at negedge, sample one ns after the capturing edge
  task automatic apply(input logic [9:0] ch, input logic v, input logic byp, input string req);
    @(negedge clk);
    in_data = ch; in_valid = v; bypass = byp;
    model_step(ch, v, byp);
    @(posedge clk); #1;
    check(req, {out_valid, out_data}, {v, m_last});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; bypass = 1'b0; in_data = 10'h3FF;
    model_reset();
    @(negedge clk);
    check("R1 in reset", {out_valid, out_data}, 11'h0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after release", {out_valid, out_data}, 11'h0);
  endtask

  task automatic t_first_char();
    do_reset();
    // single one at bit 0: taps put ones at 0,4,9; NRZI gives 0x233
    apply(10'h001, 1'b1, 1'b0, "R2 R3 single-one character");
    check("R2 R3 hand value", {1'b0, out_data}, 11'h233);
    apply(10'h000, 1'b1, 1'b0, "R2 carry across boundary");
  endtask

  task automatic t_stream();
    do_reset();
    for (int k = 0; k < 40; k++)
      apply(10'((k * 37 + 11) ^ (k << 5)), 1'b1, 1'b0, "R2 R3 stream");
  endtask

  task automatic t_gaps();
    do_reset();
    for (int k = 0; k < 20; k++) begin
      apply(10'(k * 91 + 3), 1'b1, 1'b0, "R4 before gap");
      if (k % 3 == 0) begin
        apply(10'h2AA, 1'b0, 1'b0, "R9 idle hold");
        apply(10'h155, 1'b0, 1'b1, "R9 idle hold bypass");
      end
    end
  endtask

  task automatic t_bypass();
    do_reset();
    for (int k = 0; k < 6; k++) apply(10'(k * 53 + 7), 1'b1, 1'b0, "R3 before bypass");
    for (int k = 0; k < 6; k++) begin
      apply(10'(k * 211 + 1), 1'b1, 1'b1, "R5 raw path");
      check("R5 raw equals input", {1'b0, out_data}, {1'b0, 10'(k * 211 + 1)});
    end
    apply(10'h0F3, 1'b1, 1'b0, "R7 first after bypass");
    apply(10'h31C, 1'b1, 1'b0, "R7 second after bypass");
    apply(10'h000, 1'b0, 1'b0, "R6 valid drop");
  endtask

  task automatic t_recover();
    logic [9:0] src;
    logic [9:0] enc;
    do_reset();
    s_sr = 9'h1A5; s_tp = 1'b1;
    for (int k = 0; k < 30; k++) begin
      src = 10'(k * 149 + 77);
      enc = encode(src);
      apply(enc, 1'b1, 1'b0, "R8 model");
      if (k >= 1) check("R8 recovered source", {1'b0, out_data}, {1'b0, src});
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_first_char();
    t_stream();
    t_gaps();
    t_bypass();
    t_recover();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule